// File: doc/BRIEF.md
# First-Fault Vector Load Unit

This block loads a vector of eight 64-bit elements from consecutive memory words under a governing predicate. It walks the lanes in ascending order and issues one memory request per active lane. Each response returns the data word together with a fault flag. A first-fault register, with one bit per lane, records how far a load got before it was stopped.

A fault on the lowest active lane is a genuine fault: the unit raises `trap` and leaves both the destination vector and the first-fault register exactly as they were. A fault on any later active lane is absorbed. The register bit of the faulting lane is cleared, and so is every bit above it. No further requests are issued, and the faulting lane and all lanes after it read as zero in the destination.

Software brackets a loop iteration with two commands. A set command fills the register with ones. A read returns the register ANDed with a caller-supplied predicate, so the result can govern the following operations.

Top module: `ffload`

## Requirements
- R1: After reset the first-fault register is all ones, the destination vector is zero, and `trap`, `done` and `mem_req` are low.
- R2: The request for lane i carries the address `base + ((index + i) << 3)`, computed modulo 2^AW, and lanes are requested in ascending order.
- R3: An inactive lane (predicate bit 0) issues no request, reads as zero in the destination, and leaves its first-fault bit unchanged.
- R4: When no active lane faults, the load finishes with a one-cycle `done` pulse. `trap` stays low, each active lane holds its response data, and the first-fault register is unchanged.
- R5: When the lowest active lane faults, `trap` and `done` pulse together, and the destination vector and first-fault register keep their previous values.
- R6: When a later active lane j faults, `trap` stays low, register bits j and above are cleared, and bits below j are kept.
- R7: After an absorbed fault on lane j, no request is issued for any lane above j. Lanes j and above read as zero, and lanes below j keep their loaded data.
- R8: A set command (`ffr_set` high in a cycle while the unit is idle) makes every first-fault bit 1. A set command issued while a load is in progress has no effect.
- R9: `rd_mask` equals the first-fault register ANDed with `rd_pred` at all times. The read is combinational.
- R10: At most one memory request is outstanding, and a `ld_go` pulse while a load is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_go | input | 1 | Start a load (accepted when idle) |
| ld_base | input | AW | Base byte address |
| ld_index | input | AW | Element index of lane 0 |
| ld_pred | input | LANES | Governing predicate, bit i for lane i |
| mem_req | output | 1 | One-cycle request strobe |
| mem_addr | output | AW | Request byte address |
| rsp_valid | input | 1 | Response strobe |
| rsp_data | input | DW | Response data |
| rsp_fault | input | 1 | Response carries a fault |
| ffr_set | input | 1 | Set all first-fault bits (when idle) |
| rd_pred | input | LANES | Predicate for the register read |
| rd_mask | output | LANES | First-fault register AND `rd_pred` |
| vec_out | output | LANES*DW | Destination vector, lane i at bits i*DW +: DW |
| ffr_out | output | LANES | First-fault register |
| trap | output | 1 | Genuine fault, pulses with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch the invariants that hold on every cycle. `trap` never appears without `done`, and a trapping load leaves the register and vector untouched. A completing load can only clear first-fault bits, never set them. A request is never followed directly by another one, and the read mask never holds a bit that is absent from either operand.

Some properties need the bench's scenarios and its memory model with a programmable fault window:
- the exact addresses and their ascending order;
- that no request appears past an absorbed fault;
- the per-lane zeroing and the precise register values after faults on early, middle and predicate-skipped positions;
- that a start or set command arriving during a busy load is ignored.

// File: rtl/ffload.sv
module ffload #(
  parameter int LANES = 8,
  parameter int DW    = 64,
  parameter int AW    = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_go,
  input  logic [AW-1:0]         ld_base,
  input  logic [AW-1:0]         ld_index,
  input  logic [LANES-1:0]      ld_pred,
  output logic                  mem_req,
  output logic [AW-1:0]         mem_addr,
  input  logic                  rsp_valid,
  input  logic [DW-1:0]         rsp_data,
  input  logic                  rsp_fault,
  input  logic                  ffr_set,
  input  logic [LANES-1:0]      rd_pred,
  output logic [LANES-1:0]      rd_mask,
  output logic [LANES*DW-1:0]   vec_out,
  output logic [LANES-1:0]      ffr_out,
  output logic                  trap,
  output logic                  done
);
  localparam int LW = $clog2(LANES);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT} st_t;

  st_t                st;
  logic [LW:0]        lane;
  logic [AW-1:0]      base_q, idx_q;
  logic [LANES-1:0]   pred_q;
  logic               seen_q;
  logic [LANES*DW-1:0] work;
  logic [LANES-1:0]   below;

  wire lane_end = (lane == (LW+1)'(LANES));
  wire cur_act  = !lane_end && pred_q[lane[LW-1:0]];

  assign mem_req  = (st == S_SCAN) && cur_act;
  assign mem_addr = base_q + ((idx_q + AW'(lane)) << 3);
  assign rd_mask  = ffr_out & rd_pred;

  always_comb
    for (int i = 0; i < LANES; i++) below[i] = (i < int'(lane));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      lane    <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      pred_q  <= '0;
      seen_q  <= 1'b0;
      work    <= '0;
      vec_out <= '0;
      ffr_out <= '1;
      trap    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      trap <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ffr_set) ffr_out <= '1;
          if (ld_go) begin
            base_q <= ld_base;
            idx_q  <= ld_index;
            pred_q <= ld_pred;
            lane   <= '0;
            seen_q <= 1'b0;
            work   <= '0;
            st     <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (lane_end) begin
            vec_out <= work;
            done    <= 1'b1;
            st      <= S_IDLE;
          end else if (cur_act) begin
            st <= S_WAIT;
          end else begin
            lane <= lane + 1'b1;
          end
        end
        S_WAIT: begin
          if (rsp_valid) begin
            if (rsp_fault) begin
              done <= 1'b1;
              st   <= S_IDLE;
              if (!seen_q) begin
                trap <= 1'b1;
              end else begin
                ffr_out <= ffr_out & below;
                vec_out <= work;
              end
            end else begin
              work[lane[LW-1:0]*DW +: DW] <= rsp_data;
              seen_q <= 1'b1;
              lane   <= lane + 1'b1;
              st     <= S_SCAN;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_trap_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> done);
  a_r5_trap_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> ($stable(ffr_out) && $stable(vec_out)));
  a_r6_load_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trap) |-> ((ffr_out & ~$past(ffr_out)) == '0));
  a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_read_subset: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_mask & ~ffr_out) == '0) && ((rd_mask & ~rd_pred) == '0));
  a_r7_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

// File: tb/ffload_test.sv
module ffload_test;
  localparam int LANES = 8, DW = 64, AW = 48;

  logic clk = 0, rst_n = 0;
  logic ld_go = 0, rsp_valid = 0, rsp_fault = 0, ffr_set = 0;
  logic [AW-1:0] ld_base = '0, ld_index = '0;
  logic [LANES-1:0] ld_pred = '0, rd_pred = '0;
  logic [DW-1:0] rsp_data = '0;
  logic mem_req, trap, done;
  logic [AW-1:0] mem_addr;
  logic [LANES-1:0] rd_mask, ffr_out;
  logic [LANES*DW-1:0] vec_out;

  ffload #(.LANES(LANES), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ld_go(ld_go), .ld_base(ld_base), .ld_index(ld_index),
    .ld_pred(ld_pred), .mem_req(mem_req), .mem_addr(mem_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_fault(rsp_fault), .ffr_set(ffr_set), .rd_pred(rd_pred),
    .rd_mask(rd_mask), .vec_out(vec_out), .ffr_out(ffr_out), .trap(trap), .done(done));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, done_cnt = 0, cyc = 0;
  logic [AW-1:0] flo = '0, fhi = '0;
  logic [AW-1:0] aq[$];
  string aq_tag[$];
  logic [LANES*DW-1:0] vq[$];
  logic [LANES-1:0] fq[$];
  logic tq[$];
  string rq[$];
  logic [LANES*DW-1:0] m_vec = '0;
  logic [LANES-1:0] m_ffr = '1;

  function automatic void chk(bit ok, string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  // memory model: replies one cycle after the request
  logic pend = 0;
  logic [AW-1:0] paddr;
  always @(negedge clk) begin
    rsp_valid = 0;
    if (pend) begin
      rsp_valid = 1;
      rsp_data  = {16'hD00D, paddr};
      rsp_fault = (paddr >= flo) && (paddr < fhi);
      pend = 0;
    end
    if (rst_n && mem_req) begin
      pend = 1;
      paddr = mem_addr;
    end
  end

  // monitor: addresses and results
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (aq.size() == 0) chk(0, "R7", "unexpected request", mem_addr, 0);
      else begin
        logic [AW-1:0] a;
        string t;
        a = aq.pop_front();
        t = aq_tag.pop_front();
        chk(a === mem_addr, t, "request address", mem_addr, a);
      end
    end
    if (rst_n && done) begin
      if (vq.size() == 0) chk(0, "R10", "unexpected done", 0, 0);
      else begin
        logic [LANES*DW-1:0] v;
        logic [LANES-1:0] f;
        logic t;
        string r;
        v = vq.pop_front(); f = fq.pop_front(); t = tq.pop_front(); r = rq.pop_front();
        chk(vec_out === v, r, "vector", vec_out, v);
        chk(ffr_out === f, r, "ffr", ffr_out, f);
        chk(trap === t, r, "trap", trap, t);
      end
      done_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run_load(input logic [AW-1:0] b, input logic [AW-1:0] ix, input logic [LANES-1:0] p,
                          input logic [AW-1:0] lo, input logic [AW-1:0] hi, input string req,
                          input bit poke);
    logic [LANES*DW-1:0] v = '0;
    logic [LANES-1:0] f = m_ffr;
    bit t = 0, first = 1, stop = 0;
    int d0;
    flo = lo; fhi = hi;
    for (int i = 0; i < LANES; i++) begin
      if (!stop && p[i]) begin
        logic [AW-1:0] a;
        a = b + ((ix + AW'(i)) << 3);
        aq.push_back(a); aq_tag.push_back(req);
        if (a >= lo && a < hi) begin
          if (first) t = 1;
          else f = f & LANES'((1 << i) - 1);
          stop = 1;
        end else begin
          v[i*DW +: DW] = {16'hD00D, a};
          first = 0;
        end
      end
    end
    if (t) begin v = m_vec; f = m_ffr; end
    vq.push_back(v); fq.push_back(f); tq.push_back(t); rq.push_back(req);
    m_vec = v; m_ffr = f;
    d0 = done_cnt;
    @(negedge clk);
    ld_go = 1; ld_base = b; ld_index = ix; ld_pred = p;
    @(negedge clk);
    ld_go = 0;
    if (poke) begin
      @(negedge clk);
      ld_go = 1; ffr_set = 1; ld_base = 48'h9000; ld_pred = '1;
      @(negedge clk);
      ld_go = 0; ffr_set = 0;
    end
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic read_ffr(input logic [LANES-1:0] p, input string req);
    @(negedge clk);
    rd_pred = p;
    #1;
    chk(rd_mask === (m_ffr & p), req, "read mask", rd_mask, m_ffr & p);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ffr_out === '1 && vec_out === '0, "R1", "reset ffr/vector", {ffr_out, vec_out[63:0]}, {8'hFF, 64'h0});
    chk(!trap && !done && !mem_req, "R1", "reset strobes", {trap, done, mem_req}, 0);
    rst_n = 1;
    read_ffr(8'h5A, "R9");
    run_load(48'h1000, 48'h0, 8'hFF, 0, 0, "R4", 0);
    run_load(48'h1100, 48'h3, 8'b1010_0110, 0, 0, "R3", 0);
    run_load(48'hFFFF_FFFF_FFF0, 48'h1, 8'h0F, 0, 0, "R2", 0);
    run_load(48'h2000, 48'h0, 8'hFF, 48'h2018, 48'h3000, "R6", 0);
    read_ffr(8'hFF, "R9");
    run_load(48'h2000, 48'h0, 8'hF0, 48'h2018, 48'h3000, "R5", 0);
    read_ffr(8'h3C, "R9");
    @(negedge clk); ffr_set = 1; @(negedge clk); ffr_set = 0;
    m_ffr = '1;
    read_ffr(8'hFF, "R8");
    run_load(48'h4000, 48'h2, 8'b1011_0011, 48'h4038, 48'h5000, "R7", 0);
    run_load(48'h6000, 48'h0, 8'hFF, 0, 0, "R10", 1);
    read_ffr(8'hFF, "R8");
    run_load(48'h7000, 48'h0, 8'h00, 0, 0, "R3", 0);
    @(negedge clk); @(negedge clk);
    chk(aq.size() == 0 && vq.size() == 0, "R7", "leftover expectations", aq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule